// File: doc/BRIEF.md
# Loopback UART Register File

This block presents a byte-wide register window laid out like a classic 16550-style serial port, with no serial line behind it. Bytes written to the data offset go into one circular FIFO, and reads of the same offset return them oldest first. Transmit and receive share that single FIFO. Status, interrupt identification and modem status are all derived from how full the FIFO is, from an overrun flag and from the control registers. There is no shifter, no baud clock and no modem pin.

A host drives a 3-bit offset with a read or a write strobe for one cycle. Read data is combinational in the strobe cycle. The read side effects (FIFO pop, overrun clear) and all writes take effect at the next rising clock edge. The interrupt output is a one-cycle pulse, registered, that fires when a data read leaves the FIFO empty.

Top module: `lbuart_top`

## Requirements
- R1: After reset the FIFO is empty, the overrun flag is clear, and control, scratch, divisor and interrupt-enable all hold zero. The trigger selection is 0, which means level 1. In this state line status reads 0x60, interrupt identification reads 0xC1, modem status reads 0xB3 and `irq` is low.
- R2: Bit 7 of line control is the divisor access bit. While it is 1, offset 0 reads and writes the divisor low byte and offset 1 reads and writes the divisor high byte. Neither access changes the FIFO.
- R3: While the access bit is 0, a read at offset 0 returns the oldest FIFO byte and removes it at the clock edge. A write at offset 0 appends the written byte. A read at offset 0 with the FIFO empty returns 0x00 and changes nothing.
- R4: The FIFO holds DEPTH bytes (16 by default). A write at offset 0 while the FIFO is full discards the byte and sets the overrun flag.
- R5: `irq` is high for exactly the cycle after a data read at offset 0 (access bit clear) that leaves the FIFO empty while interrupt-enable bit 1 is set. `irq` is low in every other cycle.
- R6: With the access bit clear, a read at offset 1 returns interrupt-enable bits 3:0, and bits 7:4 read as 0. A write at offset 1 stores all 8 bits.
- R7: Interrupt identification (offset 2) is the OR of four cause codes, each gated by its enable bit: 0x06 when enable bit 2 is set and overrun is flagged; 0x04 when enable bit 0 is set and the FIFO count is at or above the trigger level; 0x02 when enable bit 1 is set and the FIFO is empty; 0x00 when enable bit 3 is set and modem-control bit 0 or bit 1 is set. If the OR is zero it becomes 0x01. Bits 7:6 always read 1.
- R8: Line status (offset 5) has bit 0 set when the FIFO is not empty, bit 1 set when overrun is flagged, and bits 5 and 6 both set when the FIFO is empty. All other bits are 0. A read of line status clears overrun at the following clock edge, unless an overflowing write lands in the same cycle.
- R9: Modem status (offset 6) always has bits 7, 5 and 1 set. It also has bits 4 and 0 set, except when modem-control bit 5 is set and the FIFO is full.
- R10: Line control (offset 3), modem control (offset 4) and scratch (offset 7) read back the last byte written to them.
- R11: A write at offset 2 selects the trigger level from data bits 7:6. The values 0, 1, 2 and 3 give levels 1, DEPTH/4, DEPTH/2 and DEPTH-2 (1, 4, 8 and 14 by default).
- R12: `rd_data` is 0x00 in any cycle without `rd_en`. Writes at offsets 5 and 6 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | 3 | Register offset |
| rd_en | input | 1 | Read strobe, one cycle per access |
| wr_en | input | 1 | Write strobe, one cycle per access |
| wr_data | input | 8 | Write byte |
| rd_data | output | 8 | Read byte, valid in the strobe cycle |
| irq | output | 1 | One-cycle pulse when a data read leaves the FIFO empty |

## Verification
The assertions check the following on every cycle: the FIFO count never goes past its depth, `rd_data` is zero without a strobe, the identification byte always carries its two top bits, the interrupt-enable read keeps its upper nibble clear, and a divisor-mode read never moves the count. They also check that every `irq` pulse follows a data read, and that a line-status read clears overrun. Byte order through the FIFO, the overflow discard, the combination of identification codes, the trigger-level selection and the modem-status gating when full depend on the history of writes. Only the bench scenarios can show those, with the bench comparing each read against its own register model.

// File: rtl/lbuart_pkg.sv
// Package: shared offsets, field positions and helpers for the loopback
// register file. Assumes a byte-wide bus and a 3-bit offset.
package lbuart_pkg;

    localparam int BYTE_W = 8;
    localparam int OFS_W  = 3;

    typedef enum logic [OFS_W-1:0] {
        OFS_DATA = 3'd0,
        OFS_IEN  = 3'd1,
        OFS_IDN  = 3'd2,
        OFS_LCTL = 3'd3,
        OFS_MCTL = 3'd4,
        OFS_LSTS = 3'd5,
        OFS_MSTS = 3'd6,
        OFS_SCRT = 3'd7
    } reg_ofs_e;

    // interrupt-enable bit positions
    localparam int IEN_RXDATA = 0;
    localparam int IEN_TXEMPT = 1;
    localparam int IEN_LINE   = 2;
    localparam int IEN_MODEM  = 3;

    // control bit positions
    localparam int LCTL_DACC  = 7;
    localparam int MCTL_DTR   = 0;
    localparam int MCTL_RTS   = 1;
    localparam int MCTL_AFLOW = 5;

    // identification cause codes
    localparam logic [BYTE_W-1:0] IDN_LINE  = 8'h06;
    localparam logic [BYTE_W-1:0] IDN_RX    = 8'h04;
    localparam logic [BYTE_W-1:0] IDN_TX    = 8'h02;
    localparam logic [BYTE_W-1:0] IDN_MODEM = 8'h00;
    localparam logic [BYTE_W-1:0] IDN_NONE  = 8'h01;
    localparam logic [BYTE_W-1:0] IDN_TOP   = 8'hC0;

    // line status bits
    localparam logic [BYTE_W-1:0] LSTS_READY = 8'h01;
    localparam logic [BYTE_W-1:0] LSTS_OVR   = 8'h02;
    localparam logic [BYTE_W-1:0] LSTS_EMPTY = 8'h60;

    // modem status bits
    localparam logic [BYTE_W-1:0] MSTS_FIXED = 8'hA2;
    localparam logic [BYTE_W-1:0] MSTS_CLEAR = 8'h11;

    // Trigger level for a 2-bit selection and a FIFO depth
    function automatic int unsigned trig_level(input logic [1:0] sel,
                                               input int unsigned depth);
        case (sel)
            2'd0:    return 1;
            2'd1:    return depth / 4;
            2'd2:    return depth / 2;
            default: return depth - 2;
        endcase
    endfunction

endpackage

// File: rtl/lbuart_fifo.sv
// Module: circular byte FIFO with head/tail pointers and an occupancy count.
// Assumes DEPTH is a power of two so the pointers wrap naturally. A push
// while full is refused and reported on 'dropped'; a pop while empty is
// ignored. The oldest entry is always visible on 'tail_data'.
module lbuart_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_req,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop_req,
    output logic [WIDTH-1:0] tail_data,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty,
    output logic             push_ok,
    output logic             pop_ok,
    output logic             dropped
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] head, tail;

    // status from occupancy
    always_comb begin
        full    = (count == CNT_W'(DEPTH));
        empty   = (count == '0);
        push_ok = push_req && !full;
        pop_ok  = pop_req && !empty;
        dropped = push_req && full;
    end

    assign tail_data = mem[tail];

    // storage write at head
    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[head] <= push_data;
        end
    end

    // pointer and count update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else begin
            if (push_ok) head <= head + PTR_W'(1);
            if (pop_ok)  tail <= tail + PTR_W'(1);
            count <= count + CNT_W'(push_ok) - CNT_W'(pop_ok);
        end
    end

endmodule

// File: rtl/lbuart_regs.sv
// Module: control register bank: line control (holding the divisor access
// bit), modem control, scratch, interrupt enable, divisor, trigger selection
// and overrun flag. Assumes single-cycle write strobes; an overflow set wins
// over a same-cycle clear.
module lbuart_regs
    import lbuart_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [OFS_W-1:0]  addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              ovr_set,
    input  logic              ovr_clr,
    output logic [BYTE_W-1:0] lctl,
    output logic [BYTE_W-1:0] mctl,
    output logic [BYTE_W-1:0] scrt,
    output logic [BYTE_W-1:0] ien,
    output logic [BYTE_W-1:0] div_lo,
    output logic [BYTE_W-1:0] div_hi,
    output logic [1:0]        trig_sel,
    output logic              overrun,
    output logic              dacc
);

    assign dacc = lctl[LCTL_DACC];

    // register writes decoded by offset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lctl     <= '0;
            mctl     <= '0;
            scrt     <= '0;
            ien      <= '0;
            div_lo   <= '0;
            div_hi   <= '0;
            trig_sel <= '0;
        end else if (wr_en) begin
            case (reg_ofs_e'(addr))
                OFS_DATA: if (dacc) div_lo <= wr_data;
                OFS_IEN:  if (dacc) div_hi <= wr_data; else ien <= wr_data;
                OFS_IDN:  trig_sel <= wr_data[7:6];
                OFS_LCTL: lctl <= wr_data;
                OFS_MCTL: mctl <= wr_data;
                OFS_SCRT: scrt <= wr_data;
                default:  ;
            endcase
        end
    end

    // overrun flag: set by dropped byte, cleared after a status read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            overrun <= 1'b0;
        end else if (ovr_set) begin
            overrun <= 1'b1;
        end else if (ovr_clr) begin
            overrun <= 1'b0;
        end
    end

endmodule

// File: rtl/lbuart_rdmux.sv
// Module: combinational read path. Builds every readable byte from the
// register bank and FIFO state and selects one by offset. Returns zero
// without a read strobe. Assumes the FIFO tail entry is valid only when
// not empty.
module lbuart_rdmux
    import lbuart_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH) + 1
) (
    input  logic              rd_en,
    input  logic [OFS_W-1:0]  addr,
    input  logic [BYTE_W-1:0] lctl,
    input  logic [BYTE_W-1:0] mctl,
    input  logic [BYTE_W-1:0] scrt,
    input  logic [BYTE_W-1:0] ien,
    input  logic [BYTE_W-1:0] div_lo,
    input  logic [BYTE_W-1:0] div_hi,
    input  logic [1:0]        trig_sel,
    input  logic              overrun,
    input  logic              dacc,
    input  logic [BYTE_W-1:0] tail_data,
    input  logic [CNT_W-1:0]  count,
    input  logic              full,
    input  logic              empty,
    output logic [BYTE_W-1:0] rd_data
);

    logic [CNT_W-1:0]  trig;
    logic [BYTE_W-1:0] idn_or, idn_byte, lsts_byte, msts_byte, data_byte;

    // trigger threshold from the selection
    always_comb begin
        trig = CNT_W'(trig_level(trig_sel, DEPTH));
    end

    // identification byte: OR of enabled causes
    always_comb begin
        idn_or = '0;
        if (ien[IEN_LINE] && overrun)     idn_or |= IDN_LINE;
        if (ien[IEN_RXDATA] && count >= trig) idn_or |= IDN_RX;
        if (ien[IEN_TXEMPT] && empty)     idn_or |= IDN_TX;
        if (ien[IEN_MODEM] && (mctl[MCTL_RTS] || mctl[MCTL_DTR]))
            idn_or |= IDN_MODEM;
        idn_byte = ((idn_or == '0) ? IDN_NONE : idn_or) | IDN_TOP;
    end

    // line and modem status bytes
    always_comb begin
        lsts_byte = '0;
        if (!empty) lsts_byte |= LSTS_READY;
        if (overrun) lsts_byte |= LSTS_OVR;
        if (empty)  lsts_byte |= LSTS_EMPTY;
        msts_byte = MSTS_FIXED;
        if (!(mctl[MCTL_AFLOW] && full)) msts_byte |= MSTS_CLEAR;
    end

    // data offset: divisor low, FIFO head or zero
    always_comb begin
        if (dacc)       data_byte = div_lo;
        else if (empty) data_byte = '0;
        else            data_byte = tail_data;
    end

    // offset select
    always_comb begin
        rd_data = '0;
        if (rd_en) begin
            case (reg_ofs_e'(addr))
                OFS_DATA: rd_data = data_byte;
                OFS_IEN:  rd_data = dacc ? div_hi : {4'h0, ien[3:0]};
                OFS_IDN:  rd_data = idn_byte;
                OFS_LCTL: rd_data = lctl;
                OFS_MCTL: rd_data = mctl;
                OFS_LSTS: rd_data = lsts_byte;
                OFS_MSTS: rd_data = msts_byte;
                default:  rd_data = scrt;
            endcase
        end
    end

endmodule

// File: rtl/lbuart_top.sv
// Module: loopback UART register file top. Decodes strobes into FIFO push
// and pop, overrun set/clear and the empty-after-read interrupt pulse.
// Assumes the host issues single-cycle strobes; read data is combinational.
module lbuart_top
    import lbuart_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        addr,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [7:0]        wr_data,
    output logic [7:0]        rd_data,
    output logic              irq
);

    localparam int CNT_W = $clog2(DEPTH) + 1;

    logic [BYTE_W-1:0] lctl, mctl, scrt, ien, div_lo, div_hi, tail_data;
    logic [1:0]        trig_sel;
    logic              overrun, dacc;
    logic [CNT_W-1:0]  fifo_count, count_after;
    logic              full, empty, push_ok, pop_ok, dropped;
    logic              push_req, pop_req, lsts_rd, irq_next;

    // strobe decode
    always_comb begin
        push_req = wr_en && (reg_ofs_e'(addr) == OFS_DATA) && !dacc;
        pop_req  = rd_en && (reg_ofs_e'(addr) == OFS_DATA) && !dacc;
        lsts_rd  = rd_en && (reg_ofs_e'(addr) == OFS_LSTS);
    end

    lbuart_fifo #(.DEPTH(DEPTH), .WIDTH(BYTE_W)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .push_req(push_req), .push_data(wr_data), .pop_req(pop_req),
        .tail_data(tail_data), .count(fifo_count), .full(full),
        .empty(empty), .push_ok(push_ok), .pop_ok(pop_ok),
        .dropped(dropped)
    );

    lbuart_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .ovr_set(dropped), .ovr_clr(lsts_rd),
        .lctl(lctl), .mctl(mctl), .scrt(scrt), .ien(ien),
        .div_lo(div_lo), .div_hi(div_hi), .trig_sel(trig_sel),
        .overrun(overrun), .dacc(dacc)
    );

    lbuart_rdmux #(.DEPTH(DEPTH)) u_rdmux (
        .rd_en(rd_en), .addr(addr), .lctl(lctl), .mctl(mctl),
        .scrt(scrt), .ien(ien), .div_lo(div_lo), .div_hi(div_hi),
        .trig_sel(trig_sel), .overrun(overrun), .dacc(dacc),
        .tail_data(tail_data), .count(fifo_count), .full(full),
        .empty(empty), .rd_data(rd_data)
    );

    // interrupt condition: data read leaves the FIFO empty
    always_comb begin
        count_after = fifo_count + CNT_W'(push_ok) - CNT_W'(pop_ok);
        irq_next    = pop_req && ien[IEN_TXEMPT] && (count_after == '0);
    end

    // registered one-cycle interrupt pulse
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= irq_next;
    end

endmodule

// File: rtl/lbuart_chk.sv
// Checker: temporal properties of the loopback register file, bound to the
// top. Assumes it sees the top's FIFO count, overrun flag and access bit.
module lbuart_chk #(
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH) + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       addr,
    input logic             rd_en,
    input logic             wr_en,
    input logic [7:0]       rd_data,
    input logic             irq,
    input logic [CNT_W-1:0] fifo_count,
    input logic             overrun,
    input logic             dacc
);

    // R4
    fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_count <= CNT_W'(DEPTH));

    // R12
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> rd_data == 8'h00);

    // R7
    idn_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 3'd2) |-> rd_data[7:6] == 2'b11);

    // R6
    ien_nibble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 3'd1 && !dacc) |-> rd_data[7:4] == 4'h0);

    // R2
    div_read_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && addr == 3'd0 && dacc) |=> $stable(fifo_count));

    // R5
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(rd_en && addr == 3'd0 && !dacc));

    // R8
    ovr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && addr == 3'd5) |=> !overrun);

endmodule

bind lbuart_top lbuart_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
    .rd_data(rd_data), .irq(irq), .fifo_count(fifo_count),
    .overrun(overrun), .dacc(dacc)
);

// File: tb/test_lbuart_top.sv
// Bench: directed corner cases plus seeded random accesses, each read and
// each interrupt cycle compared against a register model kept here.
module test_lbuart_top;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] addr = '0;
    logic       rd_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       irq;

    int n_tests = 0;
    int n_fail  = 0;

    // model state
    logic [7:0] q [$];
    logic [7:0] m_lctl = 0, m_mctl = 0, m_scrt = 0, m_ien = 0, m_dl = 0, m_dh = 0;
    logic [1:0] m_trig = 0;
    logic       m_ovr = 0;

    lbuart_top #(.DEPTH(DEPTH)) i_lbuart_top (
        .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int trig_of(input logic [1:0] s);
        case (s)
            2'd0: return 1;
            2'd1: return DEPTH / 4;
            2'd2: return DEPTH / 2;
            default: return DEPTH - 2;
        endcase
    endfunction

    function automatic logic [7:0] exp_read(input logic [2:0] a);
        logic [7:0] v;
        logic dl;
        dl = m_lctl[7];
        case (a)
            3'd0: v = dl ? m_dl : ((q.size() != 0) ? q[0] : 8'h00);
            3'd1: v = dl ? m_dh : {4'h0, m_ien[3:0]};
            3'd2: begin
                v = 0;
                if (m_ien[2] && m_ovr) v |= 8'h06;
                if (m_ien[0] && q.size() >= trig_of(m_trig)) v |= 8'h04;
                if (m_ien[1] && q.size() == 0) v |= 8'h02;
                if (v == 0) v = 8'h01;
                v |= 8'hC0;
            end
            3'd3: v = m_lctl;
            3'd4: v = m_mctl;
            3'd5: v = ((q.size() != 0) ? 8'h01 : 8'h00) | (m_ovr ? 8'h02 : 8'h00)
                      | ((q.size() == 0) ? 8'h60 : 8'h00);
            3'd6: v = 8'hA2 | ((m_mctl[5] && q.size() == DEPTH) ? 8'h00 : 8'h11);
            default: v = m_scrt;
        endcase
        return v;
    endfunction

    function automatic string tag_of(input logic [2:0] a);
        case (a)
            3'd0: return m_lctl[7] ? "R2" : "R3";
            3'd1: return m_lctl[7] ? "R2" : "R6";
            3'd2: return "R7";
            3'd5: return "R8";
            3'd6: return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FIAL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    // one access: drive at negedge, sample read mid-cycle, check irq after edge
    task automatic access(input logic do_wr, input logic [2:0] a, input logic [7:0] d);
        logic exp_irq;
        @(negedge clk);
        addr = a; wr_en = do_wr; rd_en = !do_wr; wr_data = d;
        #(CLK_PERIOD/4);
        exp_irq = 1'b0;
        if (!do_wr) check(tag_of(a), rd_data, exp_read(a));
        else        check("R12", rd_data, 8'h00);
        @(posedge clk);
        if (do_wr) begin
            case (a)
                3'd0: if (m_lctl[7]) m_dl = d;
                      else if (q.size() == DEPTH) m_ovr = 1'b1;
                      else q.push_back(d);
                3'd1: if (m_lctl[7]) m_dh = d; else m_ien = d;
                3'd2: m_trig = d[7:6];
                3'd3: m_lctl = d;
                3'd4: m_mctl = d;
                3'd7: m_scrt = d;
                default: ;
            endcase
        end else begin
            if (a == 3'd0 && !m_lctl[7]) begin
                if (q.size() != 0) void'(q.pop_front());
                exp_irq = m_ien[1] && (q.size() == 0);
            end
            if (a == 3'd5) m_ovr = 1'b0;
        end
        #1;
        rd_en = 1'b0; wr_en = 1'b0;
        check("R5", {7'd0, irq}, {7'd0, exp_irq});
    endtask

    // watchdog
    initial begin
        #(CLK_PERIOD * 150000);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int seed;
        logic [7:0] r;
        seed = 32'h5EED_0017;
        r = 8'($urandom(seed));
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1: reset values
        access(1'b0, 3'd5, 0);
        access(1'b0, 3'd2, 0);
        access(1'b0, 3'd6, 0);
        access(1'b0, 3'd3, 0);
        check("R1", {7'd0, irq}, 8'h00);

        // R10: readback
        access(1'b1, 3'd3, 8'h1B); access(1'b0, 3'd3, 0);
        access(1'b1, 3'd4, 8'h23); access(1'b0, 3'd4, 0);
        access(1'b1, 3'd7, 8'hA5); access(1'b0, 3'd7, 0);

        // R2: divisor access, FIFO untouched
        access(1'b1, 3'd0, 8'h11);
        access(1'b1, 3'd3, 8'h80);
        access(1'b1, 3'd0, 8'h34); access(1'b1, 3'd1, 8'h12);
        access(1'b0, 3'd0, 0); access(1'b0, 3'd1, 0);
        access(1'b1, 3'd3, 8'h03);
        access(1'b0, 3'd5, 0);

        // R6: upper nibble masked
        access(1'b1, 3'd1, 8'hF2); access(1'b0, 3'd1, 0);

        // R3/R5: pop remaining byte, interrupt fires; empty pop returns zero
        access(1'b0, 3'd0, 0);
        access(1'b0, 3'd0, 0);

        // R4/R9: fill to full, overflow, modem status with auto-flow
        access(1'b1, 3'd4, 8'h20);
        for (int i = 0; i < DEPTH + 1; i++) access(1'b1, 3'd0, 8'(i * 7 + 1));
        access(1'b0, 3'd6, 0);
        access(1'b0, 3'd5, 0);
        access(1'b0, 3'd5, 0);

        // R11/R7: each trigger level against full enables
        access(1'b1, 3'd1, 8'h0F);
        for (int s = 0; s < 4; s++) begin
            access(1'b1, 3'd2, 8'(s << 6));
            for (int k = 0; k < 4; k++) begin
                access(1'b0, 3'd2, 0);
                access(1'b0, 3'd0, 0);
            end
        end

        // R12: writes to status offsets ignored
        access(1'b1, 3'd5, 8'hFF); access(1'b1, 3'd6, 8'hFF);
        access(1'b0, 3'd5, 0); access(1'b0, 3'd6, 0);

        // random mix
        for (int i = 0; i < 4000; i++) begin
            logic w;
            logic [2:0] a;
            w = ($urandom() % 2) == 0;
            a = 3'($urandom() % 8);
            if (w && a == 3'd3) r = ($urandom() % 4 == 0) ? 8'h80 : 8'h03;
            else r = 8'($urandom());
            if (w && (a == 3'd0) && ($urandom() % 3 != 0)) a = 3'd0;
            access(w, a, r);
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule